// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps the frame statistics of one Ethernet MAC port. The receive and transmit datapaths each pulse a one-cycle event when a frame completes. The event carries the frame length, three class bits and a set of error bits. From these the bank keeps frame counts, per-class and per-error counts, octet totals and a seven-bin length histogram for each direction. Every counter saturates at its maximum value instead of wrapping.

Software reads the counters through a simple port made of a read strobe and an address. The data comes back one cycle later with a valid flag, and the counter that was read is cleared at the same time. The octet totals are wider than the data word. Reading the low word clears the whole total and copies its upper bits into a shadow register, which a later read of the high word returns. A separate clear-all input zeroes the whole bank in one cycle. One counter, for frames over the programmed size limit, uses its top data bit to report whether the receive FIFO is empty.

Top module: `mac_stat_bank`

## Requirements
- R1: Frame, class, error and histogram counters are CNT_W bits wide (default 32). Each adds one per qualifying event and holds at all ones instead of wrapping.
- R2: Octet totals are OCT_W bits wide (default 45) and add the frame length of each event, saturating at all ones. The receive total is read as its low 32 bits at address 0 and its high part at address 1; the transmit total uses addresses 2 and 3. A read of the low word clears the whole total and copies bits OCT_W-1:32 into a shadow register. A read of the high word returns that shadow and clears nothing.
- R3: Each direction has a length histogram at base address 14 (receive) or 26 (transmit), offsets 0 to 6, for lengths 64, 65-127, 128-255, 256-511, 512-1023, 1024-1518 and 1519-MAX_FRAME. A length below 64 or above MAX_FRAME counts in no bin.
- R4: Receive counters: address 4 counts all frames, 5 multicast, 6 broadcast and 7 pause, selected by rx_class_i bits 0, 1 and 2. Addresses 8 to 12 count FCS error, jabber, short, symbol error and oversize, selected by rx_err_i bits 0 to 4. Transmit counters: address 21 counts all frames and 22 to 24 count multicast, broadcast and pause, selected by tx_class_i bits 0 to 2.
- R5: The transmit error counter at address 25 adds exactly one per frame when either tx_err_i bit 0 (bad FCS) or bit 1 (underrun) is set, and one even when both are set.
- R6: A cycle with rd_en_i high returns the addressed value on rd_data_o one cycle later with rd_valid_o high, and clears that counter. In any other cycle rd_valid_o is low and rd_data_o is zero.
- R7: An increment in the same cycle as the clear-on-read of the same counter is kept, so the counter restarts at that increment.
- R8: clr_all_i zeroes every counter and both shadows. Increments in the same cycle are dropped.
- R9: The size-limit error counter at address 13 counts frames with rx_err_i bit 5 in bits CNT_W-2:0 and saturates at that width. Bit 31 of its read data is rx_fifo_empty_i as sampled in the read cycle.
- R10: Addresses 33 and above read as zero and change no counter.
- R11: After reset every counter and shadow is zero, and rd_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive frame completed (one-cycle pulse) |
| rx_len_i | input | LEN_W | Receive frame length in octets |
| rx_class_i | input | 3 | Receive class: multicast, broadcast, pause |
| rx_err_i | input | 6 | Receive errors: FCS, jabber, short, symbol, oversize, size limit |
| tx_valid_i | input | 1 | Transmit frame completed (one-cycle pulse) |
| tx_len_i | input | LEN_W | Transmit frame length in octets |
| tx_class_i | input | 3 | Transmit class: multicast, broadcast, pause |
| tx_err_i | input | 2 | Transmit errors: bad FCS, underrun |
| rx_fifo_empty_i | input | 1 | Receive FIFO empty status |
| clr_all_i | input | 1 | Clear the whole bank |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 6 | Read address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |

## Verification
An event or clear that arrives in cycle n has updated the counters at the edge that ends cycle n. A read strobe in cycle n+1 is the earliest that can see it, and its data appears one edge later, so the whole path takes two edges. The bench's behavioural model uses the same ordering. Before each edge it computes the read data due at that edge from the model's state, and only then applies the cycle's events and clears. It compares rd_valid_o and rd_data_o two nanoseconds after every rising edge. Because of this, a read, an event and a clear that land in the same cycle are scored just as the requirements order them.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 32;
  localparam int N_BIN    = 7;
  localparam int FRM_BASE = 4;
  localparam int N_FRM    = 29;
  localparam int N_ADDR   = FRM_BASE + N_FRM;

  // counter slots, address = slot + FRM_BASE
  localparam int K_RX_ALL  = 0;
  localparam int K_RX_MC   = 1;
  localparam int K_RX_BC   = 2;
  localparam int K_RX_PS   = 3;
  localparam int K_RX_ERR0 = 4;
  localparam int K_RX_LIM  = 9;
  localparam int K_RX_BIN  = 10;
  localparam int K_TX_ALL  = 17;
  localparam int K_TX_MC   = 18;
  localparam int K_TX_BC   = 19;
  localparam int K_TX_PS   = 20;
  localparam int K_TX_ERR  = 21;
  localparam int K_TX_BIN  = 22;
endpackage

// File: rtl/mac_stat_cnt.sv
module mac_stat_cnt #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic             rd_clr_i,
  input  logic             inc_i,
  input  logic [INC_W-1:0] amt_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] q, base;
  logic [W:0]   sum;

  always_comb begin
    base = rd_clr_i ? '0 : q;
    sum  = {1'b0, base} + {{(W+1-INC_W){1'b0}}, amt_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= '0;
    else if (clr_all_i) q <= '0;
    else if (inc_i)     q <= sum[W] ? '1 : sum[W-1:0];
    else                q <= base;
  end

  assign q_o = q;

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_all_i && !rd_clr_i && inc_i && q == '1) |=> q == '1); // R1
  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> q == '0); // R8
  AST_KEEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_all_i && rd_clr_i && inc_i) |=> q == W'($past(amt_i))); // R7
endmodule

// File: rtl/mac_stat_bins.sv
module mac_stat_bins #(
  parameter int LEN_W     = 14,
  parameter int MAX_FRAME = 9600
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [6:0]       bin_o
);
  localparam int LO [7] = '{64, 65, 128, 256, 512, 1024, 1519};
  localparam int HI [7] = '{64, 127, 255, 511, 1023, 1518, MAX_FRAME};

  for (genvar b = 0; b < 7; b++) begin : g_bin
    assign bin_o[b] = (len_i >= LEN_W'(LO[b])) && (len_i <= LEN_W'(HI[b]));
  end
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int OCT_W     = 45,
  parameter int LEN_W     = 14,
  parameter int MAX_FRAME = 9600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  input  logic [2:0]        rx_class_i,
  input  logic [5:0]        rx_err_i,
  input  logic              tx_valid_i,
  input  logic [LEN_W-1:0]  tx_len_i,
  input  logic [2:0]        tx_class_i,
  input  logic [1:0]        tx_err_i,
  input  logic              rx_fifo_empty_i,
  input  logic              clr_all_i,
  input  logic              rd_en_i,
  input  logic [5:0]        rd_addr_i,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o
);
  localparam int HI_W = OCT_W - DATA_W;

  logic [6:0]        rx_bin, tx_bin;
  logic [N_FRM-1:0]  frm_inc;
  logic [CNT_W-1:0]  frm_q [N_FRM];
  logic [OCT_W-1:0]  oct_q [2];
  logic [HI_W-1:0]   shadow [2];
  logic [1:0]        oct_v;
  logic [LEN_W-1:0]  oct_len [2];
  logic [DATA_W-1:0] rd_d;

  mac_stat_bins #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_rx_bins (.len_i(rx_len_i), .bin_o(rx_bin));
  mac_stat_bins #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_tx_bins (.len_i(tx_len_i), .bin_o(tx_bin));

  always_comb begin
    frm_inc = '0;
    frm_inc[K_RX_ALL] = rx_valid_i;
    frm_inc[K_RX_MC]  = rx_valid_i & rx_class_i[0];
    frm_inc[K_RX_BC]  = rx_valid_i & rx_class_i[1];
    frm_inc[K_RX_PS]  = rx_valid_i & rx_class_i[2];
    for (int e = 0; e < 6; e++) frm_inc[K_RX_ERR0+e] = rx_valid_i & rx_err_i[e];
    for (int b = 0; b < N_BIN; b++) begin
      frm_inc[K_RX_BIN+b] = rx_valid_i & rx_bin[b];
      frm_inc[K_TX_BIN+b] = tx_valid_i & tx_bin[b];
    end
    frm_inc[K_TX_ALL] = tx_valid_i;
    frm_inc[K_TX_MC]  = tx_valid_i & tx_class_i[0];
    frm_inc[K_TX_BC]  = tx_valid_i & tx_class_i[1];
    frm_inc[K_TX_PS]  = tx_valid_i & tx_class_i[2];
    frm_inc[K_TX_ERR] = tx_valid_i & (|tx_err_i);
  end

  for (genvar k = 0; k < N_FRM; k++) begin : g_frm
    localparam int CW = (k == K_RX_LIM) ? CNT_W - 1 : CNT_W;
    logic [CW-1:0] q;
    mac_stat_cnt #(.W(CW), .INC_W(1)) u_cnt (
      .clk_i, .rst_ni, .clr_all_i,
      .rd_clr_i (rd_en_i && rd_addr_i == 6'(k + FRM_BASE)),
      .inc_i    (frm_inc[k]),
      .amt_i    (1'b1),
      .q_o      (q)
    );
    assign frm_q[k] = CNT_W'(q);
  end

  assign oct_v      = {tx_valid_i, rx_valid_i};
  assign oct_len[0] = rx_len_i;
  assign oct_len[1] = tx_len_i;

  for (genvar d = 0; d < 2; d++) begin : g_oct
    logic lo_rd;
    assign lo_rd = rd_en_i && rd_addr_i == 6'(2 * d);
    mac_stat_cnt #(.W(OCT_W), .INC_W(LEN_W)) u_cnt (
      .clk_i, .rst_ni, .clr_all_i,
      .rd_clr_i (lo_rd),
      .inc_i    (oct_v[d]),
      .amt_i    (oct_len[d]),
      .q_o      (oct_q[d])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        shadow[d] <= '0;
      else if (clr_all_i) shadow[d] <= '0;
      else if (lo_rd)     shadow[d] <= oct_q[d][OCT_W-1:DATA_W];
    end
    AST_SHADOW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_all_i |=> shadow[d] == '0); // R8
  end

  always_comb begin
    rd_d = '0;
    for (int d = 0; d < 2; d++) begin
      if (rd_addr_i == 6'(2 * d))     rd_d = oct_q[d][DATA_W-1:0];
      if (rd_addr_i == 6'(2 * d + 1)) rd_d = DATA_W'(shadow[d]);
    end
    for (int k = 0; k < N_FRM; k++)
      if (rd_addr_i == 6'(k + FRM_BASE)) rd_d = DATA_W'(frm_q[k]);
    if (rd_addr_i == 6'(K_RX_LIM + FRM_BASE)) rd_d[DATA_W-1] = rx_fifo_empty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      rd_data_o  <= rd_en_i ? rd_d : '0;
    end
  end

  AST_RD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o); // R6
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_valid_o && rd_data_o == '0)); // R6
  AST_BIN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_bin) && $onehot0(tx_bin)); // R3
endmodule

// File: tb/tb_mac_stat_bank.sv
module tb_mac_stat_bank;
  localparam int CNT_W = 8, OCT_W = 45, LEN_W = 24, MAXF = 9600;
  localparam longint unsigned FMAX = (64'd1 << CNT_W) - 1;
  localparam longint unsigned LMAX = (64'd1 << (CNT_W - 1)) - 1;
  localparam longint unsigned OMAX = (64'd1 << OCT_W) - 1;

  logic clk_i = 0, rst_ni = 0;
  logic rx_valid_i = 0, tx_valid_i = 0, rx_fifo_empty_i = 0, clr_all_i = 0, rd_en_i = 0;
  logic [LEN_W-1:0] rx_len_i = 0, tx_len_i = 0;
  logic [2:0] rx_class_i = 0, tx_class_i = 0;
  logic [5:0] rx_err_i = 0;
  logic [1:0] tx_err_i = 0;
  logic [5:0] rd_addr_i = 0;
  logic rd_valid_o;
  logic [31:0] rd_data_o;

  mac_stat_bank #(.CNT_W(CNT_W), .OCT_W(OCT_W), .LEN_W(LEN_W), .MAX_FRAME(MAXF)) dut (.*);

  always #4 clk_i = ~clk_i;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string req = "R11";
  longint unsigned frm [29];
  longint unsigned oct [2];
  longint unsigned sh [2];

  function automatic int bin_of(longint unsigned l);
    if (l == 64) return 0;
    if (l >= 65 && l <= 127) return 1;
    if (l >= 128 && l <= 255) return 2;
    if (l >= 256 && l <= 511) return 3;
    if (l >= 512 && l <= 1023) return 4;
    if (l >= 1024 && l <= 1518) return 5;
    if (l >= 1519 && l <= MAXF) return 6;
    return -1;
  endfunction

  function automatic longint unsigned model_read(int a);
    if (a == 0) return oct[0] & 64'hffff_ffff;
    if (a == 1) return sh[0];
    if (a == 2) return oct[1] & 64'hffff_ffff;
    if (a == 3) return sh[1];
    if (a >= 4 && a < 33) begin
      if (a == 13) return frm[9] | (longint'(rx_fifo_empty_i) << 31);
      return frm[a-4];
    end
    return 0;
  endfunction

  task automatic step();
    longint unsigned e = 0, base, mx;
    bit ev = rd_en_i;
    bit [28:0] inc = '0;
    int b;
    if (rd_en_i) e = model_read(int'(rd_addr_i));
    if (rx_valid_i) begin
      inc[0] = 1; inc[1] = rx_class_i[0]; inc[2] = rx_class_i[1]; inc[3] = rx_class_i[2];
      for (int i = 0; i < 6; i++) inc[4+i] = rx_err_i[i];
      b = bin_of(longint'(rx_len_i)); if (b >= 0) inc[10+b] = 1;
    end
    if (tx_valid_i) begin
      inc[17] = 1; inc[18] = tx_class_i[0]; inc[19] = tx_class_i[1]; inc[20] = tx_class_i[2];
      inc[21] = |tx_err_i;
      b = bin_of(longint'(tx_len_i)); if (b >= 0) inc[22+b] = 1;
    end
    if (clr_all_i) begin
      for (int k = 0; k < 29; k++) frm[k] = 0;
      for (int d = 0; d < 2; d++) begin oct[d] = 0; sh[d] = 0; end
    end else begin
      for (int k = 0; k < 29; k++) begin
        base = (rd_en_i && rd_addr_i == 6'(k + 4)) ? 0 : frm[k];
        mx = (k == 9) ? LMAX : FMAX;
        if (inc[k]) base = (base + 1 > mx) ? mx : base + 1;
        frm[k] = base;
      end
      for (int d = 0; d < 2; d++) begin
        bit lo = rd_en_i && rd_addr_i == 6'(2 * d);
        if (lo) sh[d] = oct[d] >> 32;
        base = lo ? 0 : oct[d];
        if (d == 0 ? rx_valid_i : tx_valid_i) begin
          base = base + longint'(d == 0 ? rx_len_i : tx_len_i);
          if (base > OMAX) base = OMAX;
        end
        oct[d] = base;
      end
    end
    @(posedge clk_i); #2;
    vectors++;
    if (rd_valid_o !== ev || rd_data_o !== 32'(e)) begin
      miscompares++;
      $display("FAIL %s: valid=%0b data=%0h expected valid=%0b data=%0h", req, rd_valid_o, rd_data_o, ev, 32'(e));
    end
    rx_valid_i = 0; tx_valid_i = 0; rd_en_i = 0; clr_all_i = 0;
    rx_err_i = 0; tx_err_i = 0; rx_class_i = 0; tx_class_i = 0;
  endtask

  task automatic rd(int a);
    rd_en_i = 1; rd_addr_i = 6'(a); step();
  endtask

  task automatic rx(int l, bit [2:0] c, bit [5:0] er);
    rx_valid_i = 1; rx_len_i = LEN_W'(l); rx_class_i = c; rx_err_i = er; step();
  endtask

  task automatic tx(int l, bit [2:0] c, bit [1:0] er);
    tx_valid_i = 1; tx_len_i = LEN_W'(l); tx_class_i = c; tx_err_i = er; step();
  endtask

  task automatic rd_all();
    for (int a = 0; a < 33; a++) rd(a);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int lens [14] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 9601};
    for (int k = 0; k < 29; k++) frm[k] = 0;
    for (int d = 0; d < 2; d++) begin oct[d] = 0; sh[d] = 0; end
    repeat (3) @(posedge clk_i);
    #2;
    vectors++;
    if (rd_valid_o !== 1'b0) begin
      miscompares++;
      $display("FAIL R11: valid=%0b expected valid=0 in reset", rd_valid_o);
    end
    rst_ni = 1;
    @(posedge clk_i); #2;
    req = "R11"; rd_all();
    req = "R10"; rd(40); rd(63);

    req = "R4"; rx(64, 3'b001, 6'b0); rx(100, 3'b010, 6'b0); rx(70, 3'b100, 6'b0);
    for (int e = 0; e < 5; e++) rx(200, 3'b0, 6'(1 << e));
    tx(64, 3'b001, 2'b0); tx(80, 3'b110, 2'b0);
    rd_all();
    req = "R6"; rd(4); rd(4); rd(21);

    req = "R3";
    foreach (lens[i]) begin rx(lens[i], 3'b0, 6'b0); tx(lens[i], 3'b0, 2'b0); end
    rx(9600, 3'b0, 6'b0); tx(9600, 3'b0, 2'b0);
    for (int a = 14; a < 21; a++) rd(a);
    for (int a = 26; a < 33; a++) rd(a);

    req = "R5"; tx(100, 3'b0, 2'b01); tx(100, 3'b0, 2'b10); tx(100, 3'b0, 2'b11); tx(100, 3'b0, 2'b00);
    rd(25); rd(21);

    req = "R7"; rx(64, 3'b0, 6'b0);
    rx_valid_i = 1; rx_len_i = 300; rd_en_i = 1; rd_addr_i = 4; step();
    rd(4);
    rx_valid_i = 1; rx_len_i = 500; rd_en_i = 1; rd_addr_i = 0; step();
    rd(0); rd(1);

    req = "R10"; rx(64, 3'b0, 6'b0); rd(50); rd(4);

    req = "R8"; rx(64, 3'b001, 6'b0); tx(64, 3'b0, 2'b01);
    clr_all_i = 1; rx_valid_i = 1; rx_len_i = 64; tx_valid_i = 1; tx_len_i = 64; step();
    rd_all();

    req = "R1";
    for (int i = 0; i < 300; i++) rx(64, 3'b001, 6'b100000);
    rd(4); rd(5); rd(14);
    req = "R9"; rx_fifo_empty_i = 0; rd(13);
    for (int i = 0; i < 130; i++) rx(64, 3'b0, 6'b100000);
    rx_fifo_empty_i = 1; rd(13); rd(13);
    rx_fifo_empty_i = 0;

    req = "R2";
    rd(0);
    for (int i = 0; i < 300; i++) begin rx(16000000, 3'b0, 6'b0); tx(15000000, 3'b0, 2'b0); end
    rd(1); rd(0); rd(1);
    rx(1000, 3'b0, 6'b0); rd(1); rd(2); rd(3); rd(0); rd(1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule